// File: doc/BRIEF.md
# Framebuffer Mode Geometry Checker

This block looks at the programmed display-mode registers of a linear framebuffer (enable word, colour depth, visible width and height, virtual line width, horizontal and vertical pan) together with the size of the attached video memory. From these it derives the bytes per pixel, the line stride in bytes, the byte count of the visible frame and the byte offset of the first visible pixel. It raises a legal-mode flag only when that geometry can really be scanned out.

A small two-state machine keeps the geometry of the last legal mode. State `ST_EMPTY` means no legal mode has been seen since reset. State `ST_HOLD` means a geometry is held. The *first lock* transition (`ST_EMPTY` to `ST_HOLD`) fires on the first legal mode. In `ST_HOLD`, a legal mode whose geometry differs takes the *switch* transition back into `ST_HOLD` and replaces the held geometry. Any other input takes the *keep* transition. The first-lock and switch transitions both raise a one-cycle mode-changed pulse, which a scan-out engine uses to request a full-screen redraw.

All outputs are registered, so they appear one clock after the inputs are sampled.

Top module: `fb_mode_check`

## Requirements
- R1: When bit 0 of the enable word is 0, the mode is illegal.
- R2: A depth of 16 gives 2 bytes per pixel and format code 1 (5-6-5 RGB). A depth of 32 gives 4 bytes per pixel and format code 2 when the big-endian input is 0, or code 3 when it is 1. Every other depth is illegal.
- R3: The line stride equals the larger of the virtual width and the visible width, multiplied by the bytes per pixel.
- R4: The frame size equals the stride times the visible height. It is computed at full width with no wrap.
- R5: The start offset equals the horizontal pan times the bytes per pixel, plus the vertical pan times the stride.
- R6: A visible width or height below 64 makes the mode illegal. A value of exactly 64 is accepted.
- R7: A mode whose start offset plus frame size exceeds the video memory size is illegal. An exact fit is legal.
- R8: The mode-changed output is high for one cycle when a legal mode is the first since reset, or when its tuple (format code, width, height, stride, offset) differs from the held tuple.
- R9: Illegal modes leave the held tuple untouched and never pulse. Repeating a legal mode that is already held does not pulse.
- R10: While the legal flag is low, the format code, bytes per pixel, stride, size and offset outputs are all 0. During reset every output is 0.
- R11: Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_word | input | REG_W | Enable register; bit 0 turns the mode on |
| depth | input | REG_W | Bits per pixel |
| big_endian | input | 1 | Byte order for 32-bit pixels |
| vis_w | input | REG_W | Visible width in pixels |
| vis_h | input | REG_W | Visible height in lines |
| virt_w | input | REG_W | Virtual line width in pixels |
| pan_x | input | REG_W | Horizontal pan in pixels |
| pan_y | input | REG_W | Vertical pan in lines |
| mem_bytes | input | MEM_W | Video memory size in bytes |
| mode_ok | output | 1 | Mode is legal |
| pix_fmt | output | 2 | Pixel format code |
| bytes_pp | output | 3 | Bytes per pixel |
| line_stride | output | REG_W+3 | Bytes per line |
| frame_size | output | 2*REG_W+3 | Bytes in the visible frame |
| start_offs | output | 2*REG_W+4 | Byte offset of the first visible pixel |
| mode_changed | output | 1 | One-cycle geometry switch pulse |

## Verification
Rejection and change detection can land in the same cycle. A pan or geometry change that also pushes the frame past the end of memory is both a new tuple and an illegal mode. The bench provokes this by stepping the horizontal pan by one pixel on an exact-fit mode. It expects the legal flag low and no pulse. It then restores the exact-fit mode and expects no pulse, which shows the held tuple survived the rejected cycle. A disabled copy of a held mode is used the same way.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
    typedef enum logic [1:0] {
        PF_NONE     = 2'd0,
        PF_RGB565   = 2'd1,
        PF_XRGB_LE  = 2'd2,
        PF_XRGB_BE  = 2'd3
    } pix_fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } lock_st_e;
endpackage

// File: rtl/fbm_depth_map.sv
module fbm_depth_map
    import fbm_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] depth,
    input  logic             big_endian,
    output logic [2:0]       bytes_pp,
    output pix_fmt_e         fmt,
    output logic             depth_ok
);
    always_comb begin
        bytes_pp = 3'd0;
        fmt      = PF_NONE;
        depth_ok = 1'b0;
        if (depth == REG_W'(16)) begin
            bytes_pp = 3'd2;
            fmt      = PF_RGB565;
            depth_ok = 1'b1;
        end else if (depth == REG_W'(32)) begin
            bytes_pp = 3'd4;
            fmt      = big_endian ? PF_XRGB_BE : PF_XRGB_LE;
            depth_ok = 1'b1;
        end
    end
endmodule

// File: rtl/fbm_geom_calc.sv
module fbm_geom_calc #(
    parameter int REG_W = 16,
    localparam int STRIDE_W = REG_W + 3,
    localparam int SIZE_W   = STRIDE_W + REG_W,
    localparam int OFFS_W   = SIZE_W + 1
) (
    input  logic [2:0]          bytes_pp,
    input  logic [REG_W-1:0]    vis_w,
    input  logic [REG_W-1:0]    vis_h,
    input  logic [REG_W-1:0]    virt_w,
    input  logic [REG_W-1:0]    pan_x,
    input  logic [REG_W-1:0]    pan_y,
    output logic [STRIDE_W-1:0] stride,
    output logic [SIZE_W-1:0]   size,
    output logic [OFFS_W-1:0]   offs
);
    logic [REG_W-1:0] eff_w;

    always_comb begin
        eff_w  = (virt_w < vis_w) ? vis_w : virt_w;
        stride = STRIDE_W'(eff_w) * STRIDE_W'(bytes_pp);
        size   = SIZE_W'(stride) * SIZE_W'(vis_h);
        offs   = OFFS_W'(pan_x) * OFFS_W'(bytes_pp)
               + OFFS_W'(pan_y) * OFFS_W'(stride);
    end
endmodule

// File: rtl/fb_mode_check.sv
module fb_mode_check
    import fbm_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int MEM_W   = 32,
    parameter int MIN_DIM = 64,
    localparam int STRIDE_W = REG_W + 3,
    localparam int SIZE_W   = STRIDE_W + REG_W,
    localparam int OFFS_W   = SIZE_W + 1,
    localparam int SUM_W    = SIZE_W + 2,
    localparam int CMP_W    = (SUM_W > MEM_W) ? SUM_W : MEM_W,
    localparam int KEY_W    = 2 + 2 * REG_W + STRIDE_W + OFFS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    en_word,
    input  logic [REG_W-1:0]    depth,
    input  logic                big_endian,
    input  logic [REG_W-1:0]    vis_w,
    input  logic [REG_W-1:0]    vis_h,
    input  logic [REG_W-1:0]    virt_w,
    input  logic [REG_W-1:0]    pan_x,
    input  logic [REG_W-1:0]    pan_y,
    input  logic [MEM_W-1:0]    mem_bytes,
    output logic                mode_ok,
    output logic [1:0]          pix_fmt,
    output logic [2:0]          bytes_pp,
    output logic [STRIDE_W-1:0] line_stride,
    output logic [SIZE_W-1:0]   frame_size,
    output logic [OFFS_W-1:0]   start_offs,
    output logic                mode_changed
);
    logic [2:0]          c_bytes;
    pix_fmt_e            c_fmt;
    logic                c_depth_ok;
    logic [STRIDE_W-1:0] c_stride;
    logic [SIZE_W-1:0]   c_size;
    logic [OFFS_W-1:0]   c_offs;

    fbm_depth_map #(.REG_W(REG_W)) u_depth (
        .depth      (depth),
        .big_endian (big_endian),
        .bytes_pp   (c_bytes),
        .fmt        (c_fmt),
        .depth_ok   (c_depth_ok)
    );

    fbm_geom_calc #(.REG_W(REG_W)) u_geom (
        .bytes_pp (c_bytes),
        .vis_w    (vis_w),
        .vis_h    (vis_h),
        .virt_w   (virt_w),
        .pan_x    (pan_x),
        .pan_y    (pan_y),
        .stride   (c_stride),
        .size     (c_size),
        .offs     (c_offs)
    );

    logic             fits, big_enough, legal, pulse;
    logic [KEY_W-1:0] cur_key, held_key;
    lock_st_e         st_q, st_d;

    always_comb begin
        fits       = (CMP_W'(c_offs) + CMP_W'(c_size)) <= CMP_W'(mem_bytes);
        big_enough = (vis_w >= REG_W'(MIN_DIM)) && (vis_h >= REG_W'(MIN_DIM));
        legal      = en_word[0] && c_depth_ok && big_enough && fits;
        cur_key    = {c_fmt, vis_w, vis_h, c_stride, c_offs};
    end

    // next-state and pulse decode
    always_comb begin
        st_d  = st_q;
        pulse = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                if (legal) begin
                    st_d  = ST_HOLD;   // first lock
                    pulse = 1'b1;
                end
            end
            ST_HOLD: begin
                st_d  = ST_HOLD;       // switch or keep
                pulse = legal && (cur_key != held_key);
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // state register with held geometry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_EMPTY;
            held_key <= '0;
        end else begin
            st_q <= st_d;
            if (legal) held_key <= cur_key;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ok      <= 1'b0;
            pix_fmt      <= 2'd0;
            bytes_pp     <= 3'd0;
            line_stride  <= '0;
            frame_size   <= '0;
            start_offs   <= '0;
            mode_changed <= 1'b0;
        end else begin
            mode_ok      <= legal;
            pix_fmt      <= legal ? c_fmt    : PF_NONE;
            bytes_pp     <= legal ? c_bytes  : 3'd0;
            line_stride  <= legal ? c_stride : '0;
            frame_size   <= legal ? c_size   : '0;
            start_offs   <= legal ? c_offs   : '0;
            mode_changed <= pulse;
        end
    end

    AST_EN_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok |-> $past(en_word[0])); // R1
    AST_MIN_DIM: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok |-> ($past(vis_w) >= REG_W'(MIN_DIM) && $past(vis_h) >= REG_W'(MIN_DIM))); // R6
    AST_STRIDE_COVERS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok |-> (64'(line_stride) >= 64'($past(vis_w)) * 64'(bytes_pp))); // R3
    AST_FITS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok |-> ((CMP_W'(start_offs) + CMP_W'(frame_size)) <= CMP_W'($past(mem_bytes)))); // R7
    AST_PULSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_changed |-> mode_ok); // R9
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> (pix_fmt == 2'd0 && bytes_pp == 3'd0 && frame_size == '0)); // R10
endmodule

// File: tb/test_fb_mode_check.sv
module test_fb_mode_check;
    localparam int REG_W = 16;
    localparam int MEM_W = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [REG_W-1:0]   en_word = '0, depth = '0, vis_w = '0, vis_h = '0;
    logic [REG_W-1:0]   virt_w = '0, pan_x = '0, pan_y = '0;
    logic               big_endian = 1'b0;
    logic [MEM_W-1:0]   mem_bytes = '0;
    logic               mode_ok, mode_changed;
    logic [1:0]         pix_fmt;
    logic [2:0]         bytes_pp;
    logic [18:0]        line_stride;
    logic [34:0]        frame_size;
    logic [35:0]        start_offs;

    fb_mode_check i_fb_mode_check (
        .clk(clk), .rst_n(rst_n), .en_word(en_word), .depth(depth),
        .big_endian(big_endian), .vis_w(vis_w), .vis_h(vis_h),
        .virt_w(virt_w), .pan_x(pan_x), .pan_y(pan_y), .mem_bytes(mem_bytes),
        .mode_ok(mode_ok), .pix_fmt(pix_fmt), .bytes_pp(bytes_pp),
        .line_stride(line_stride), .frame_size(frame_size),
        .start_offs(start_offs), .mode_changed(mode_changed)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic           ok;
        logic [1:0]     fmt;
        longint unsigned bpp, stride, size, offs;
        logic           chg;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    bit              have_lock = 0;
    logic [1:0]      l_fmt;
    longint unsigned l_w, l_h, l_st, l_of;

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(string tag, logic en, int dep, logic be, int w, int h,
                         int vw, int px, int py, longint unsigned mem);
        exp_t e;
        longint unsigned bp, ew, st, sz, of;
        logic [1:0] f;
        @(negedge clk);
        en_word = REG_W'(en); depth = REG_W'(dep); big_endian = be;
        vis_w = REG_W'(w); vis_h = REG_W'(h); virt_w = REG_W'(vw);
        pan_x = REG_W'(px); pan_y = REG_W'(py); mem_bytes = MEM_W'(mem);
        bp = (dep == 16) ? 2 : (dep == 32) ? 4 : 0;
        f  = (dep == 16) ? 2'd1 : (dep == 32) ? (be ? 2'd3 : 2'd2) : 2'd0;
        ew = (longint'(vw) < longint'(w)) ? longint'(w) : longint'(vw);
        st = ew * bp; sz = st * longint'(h); of = longint'(px) * bp + longint'(py) * st;
        e.tag = tag;
        e.ok  = en && bp != 0 && w >= 64 && h >= 64 && (of + sz <= mem);
        e.chg = e.ok && (!have_lock || f != l_fmt || w != l_w || h != l_h
                         || st != l_st || of != l_of);
        if (e.ok) begin
            have_lock = 1; l_fmt = f; l_w = w; l_h = h; l_st = st; l_of = of;
            e.fmt = f; e.bpp = bp; e.stride = st; e.size = sz; e.offs = of;
        end else begin
            e.fmt = 0; e.bpp = 0; e.stride = 0; e.size = 0; e.offs = 0;
        end
        q.push_back(e);
    endtask

    // monitor: results appear one edge after the vector (R11)
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " R11 legal"}, mode_ok, e.ok);
            check({e.tag, " R2 fmt"}, pix_fmt, e.fmt);
            check({e.tag, " R2 bytes"}, bytes_pp, e.bpp);
            check({e.tag, " R3 stride"}, line_stride, e.stride);
            check({e.tag, " R4 size"}, frame_size, e.size);
            check({e.tag, " R5 offset"}, start_offs, e.offs);
            check({e.tag, " R8 changed"}, mode_changed, e.chg);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset legal", mode_ok, 0);
        check("R10 reset stride", line_stride, 0);
        check("R10 reset changed", mode_changed, 0);
        @(negedge clk); rst_n = 1'b1;
        apply("R8 first",        1, 32, 0, 640, 480, 0, 0, 0, 16777216);
        apply("R9 repeat",       1, 32, 0, 640, 480, 0, 0, 0, 16777216);
        apply("R5 pan",          1, 16, 0, 800, 600, 1024, 8, 2, 16777216);
        apply("R1 disabled",     0, 16, 0, 800, 600, 1024, 8, 2, 16777216);
        apply("R9 restore",      1, 16, 0, 800, 600, 1024, 8, 2, 16777216);
        apply("R2 depth24",      1, 24, 0, 800, 600, 0, 0, 0, 16777216);
        apply("R6 width63",      1, 32, 0, 63, 480, 0, 0, 0, 16777216);
        apply("R6 min64",        1, 32, 0, 64, 64, 0, 0, 0, 16777216);
        apply("R6 height63",     1, 32, 0, 64, 63, 0, 0, 0, 16777216);
        apply("R2 bigendian",    1, 32, 1, 640, 480, 0, 0, 0, 16777216);
        apply("R7 exactfit",     1, 32, 0, 1024, 1024, 1024, 0, 0, 4194304);
        apply("R7 overflow",     1, 32, 0, 1024, 1024, 1024, 1, 0, 4194304);
        apply("R9 afterreject",  1, 32, 0, 1024, 1024, 1024, 0, 0, 4194304);
        apply("R4 wide",         1, 32, 0, 65535, 65535, 0, 0, 0, 64'hFFFF_FFFF);
        apply("R3 clamp",        1, 16, 0, 800, 600, 100, 0, 0, 16777216);
        apply("R4 big",          1, 32, 0, 16384, 16383, 16384, 3, 0, 64'hFFFF_FFFF);
        repeat (3) @(posedge clk);
        #3;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule